// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes a small processor from normal execution into an interrupt handler. Each interrupt source supplies a flag and an enable bit. When a request is pending, the global mask bit in the condition-code byte is clear, and the processor signals that an instruction has just finished, the sequencer records the winning source and copies the processor's program counter, index register, accumulator, condition codes and stack pointer. It then writes five bytes to the stack, one per cycle, moving downward through memory. Next it pulses a request that tells the processor to set its mask bit. Last, it reads the two-byte handler address for the winning source from the vector table.

The sequencer drives a plain byte-wide memory port. A read strobe in one cycle returns its data on the read-data input in the next cycle. When the sequence ends, a one-cycle done pulse presents the 16-bit handler address for loading into the program counter, together with the stack pointer after the pushes. Source `i` has its vector at `VEC_BASE + 2*i`, so a higher index means a higher vector address and a higher priority.

Top module: `irq_entry_seq`

## Requirements
- R1: A source counts as pending only when its `src_flag` bit and its `src_en` bit are both 1. A flag whose enable is 0 never starts a sequence.
- R2: While `ccr_i[3]` (the global mask bit) is 1, no sequence starts. A request that stays asserted is taken once the bit returns to 0.
- R3: A sequence starts only on a clock edge at which `insn_done` is 1. `busy` goes high in the cycle after that edge.
- R4: The push phase takes five consecutive cycles with `mem_wr` high. The bytes are, in order, PC[7:0], PC[15:8], X, A and CCR, written to addresses SP, SP-1, SP-2, SP-3 and SP-4, where SP is the value of `sp_i` at the start.
- R5: `mask_set` is high for exactly the one cycle after the last push. No memory access happens in that cycle, and the vector read follows in the next cycle.
- R6: The vector fetch reads the high byte of the handler from `VEC_BASE + 2*i` and then the low byte from the next address, in consecutive cycles. Each byte is taken from `mem_rdata` one cycle after its read strobe.
- R7: When several sources are pending, the one with the highest index (and therefore the highest vector address) wins.
- R8: The winner is fixed on the start edge. A higher-priority source that becomes pending during the pushes does not change the vector that is fetched.
- R9: `vec_done` is a single-cycle pulse, two cycles after the low-byte read strobe. It comes with `handler` = {high byte, low byte} and `sp_o` = SP-5. `busy` drops in the following cycle.
- R10: After reset the block is idle: `busy`, `mem_wr`, `mem_rd`, `mask_set` and `vec_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_done | input | 1 | Instruction boundary: the current instruction has finished |
| src_flag | input | N_SRC | Per-source request flags |
| src_en | input | N_SRC | Per-source local enables |
| ccr_i | input | 8 | Current condition-code byte; bit 3 is the global mask |
| pc_i | input | 16 | Current program counter |
| x_i | input | 8 | Current index register |
| a_i | input | 8 | Current accumulator |
| sp_i | input | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_rd` |
| mask_set | output | 1 | One-cycle request to set the global mask bit |
| busy | output | 1 | Entry sequence in progress |
| vec_done | output | 1 | One-cycle pulse: the handler address is valid |
| handler | output | 16 | Fetched handler address |
| sp_o | output | 16 | Stack pointer after the pushes |

## Verification
A wrong state encoding or a wrong step counter shows up within one cycle as a write burst that is too short or too long, or as a read strobe that overlaps a write. A winning index that was latched wrongly, or that changes during the pushes, shows up about seven cycles after the start as a vector read address outside the expected slot. A stack pointer that is decremented wrongly shows up on the very next push address and again in `sp_o` at the done pulse. A byte captured in the wrong cycle appears only in `handler`, ten cycles after the start.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_SETI,
        ST_RDHI,
        ST_RDLO,
        ST_GETLO,
        ST_DONE
    } seq_st_t;

    localparam int unsigned PUSH_BYTES = 5;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned N_SRC = 7,
    parameter int unsigned IW    = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] flag,
    input  logic [N_SRC-1:0] en,
    output logic             any,
    output logic [IW-1:0]    idx
);

    logic [N_SRC-1:0] pend;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_pend
            assign pend[g] = flag[g] & en[g];
        end
    endgenerate

    // later (higher index) entries overwrite earlier ones: highest wins
    always_comb begin
        idx = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i]) idx = IW'(i);
        end
    end

    assign any = |pend;

endmodule

// File: rtl/irq_push_mux.sv
module irq_push_mux #(
    parameter int unsigned DW = 8,
    parameter int unsigned NB = 5,
    parameter int unsigned CW = 3
) (
    input  logic [NB*DW-1:0] img,
    input  logic [CW-1:0]    sel,
    output logic [DW-1:0]    byte_o
);

    logic [DW-1:0] lane [NB];

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_lane
            assign lane[g] = img[g*DW +: DW];
        end
    endgenerate

    always_comb begin
        byte_o = '0;
        for (int i = 0; i < NB; i++) begin
            if (sel == CW'(i)) byte_o = lane[i];
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int unsigned    N_SRC    = 7,
    parameter int unsigned    AW       = 16,
    parameter int unsigned    DW       = 8,
    parameter int unsigned    I_BIT    = 3,
    parameter logic [15:0]    VEC_BASE = 16'hFFC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic [N_SRC-1:0] src_flag,
    input  logic [N_SRC-1:0] src_en,
    input  logic [DW-1:0]    ccr_i,
    input  logic [AW-1:0]    pc_i,
    input  logic [DW-1:0]    x_i,
    input  logic [DW-1:0]    a_i,
    input  logic [AW-1:0]    sp_i,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_wr,
    output logic             mem_rd,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             mask_set,
    output logic             busy,
    output logic             vec_done,
    output logic [2*DW-1:0]  handler,
    output logic [AW-1:0]    sp_o
);

    localparam int unsigned IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int unsigned NB    = PUSH_BYTES;
    localparam int unsigned CW    = $clog2(NB);
    localparam int unsigned IMG_W = NB * DW;

    typedef struct packed {
        seq_st_t          st;
        logic [CW-1:0]    cnt;
        logic [IW-1:0]    win;
        logic [AW-1:0]    sp;
        logic [IMG_W-1:0] img;
        logic [DW-1:0]    hi;
        logic [DW-1:0]    lo;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic          pick_any;
    logic [IW-1:0] pick_idx;
    logic [DW-1:0] push_byte;
    logic [AW-1:0] vec_addr;

    irq_prio_pick #(
        .N_SRC (N_SRC),
        .IW    (IW)
    ) u_pick (
        .flag (src_flag),
        .en   (src_en),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    irq_push_mux #(
        .DW (DW),
        .NB (NB),
        .CW (CW)
    ) u_mux (
        .img    (r_q.img),
        .sel    (r_q.cnt),
        .byte_o (push_byte)
    );

    assign vec_addr = AW'(VEC_BASE) + (AW'(r_q.win) << 1);

    always_comb begin
        r_d       = r_q;
        mem_addr  = '0;
        mem_wr    = 1'b0;
        mem_rd    = 1'b0;
        mem_wdata = '0;
        mask_set  = 1'b0;
        vec_done  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (insn_done && !ccr_i[I_BIT] && pick_any) begin
                    r_d.st  = ST_PUSH;
                    r_d.cnt = '0;
                    r_d.win = pick_idx;
                    r_d.sp  = sp_i;
                    // lane 0 is pushed first: PC low, PC high, X, A, CCR
                    r_d.img = {ccr_i, a_i, x_i, pc_i[AW-1:DW], pc_i[DW-1:0]};
                end
            end
            ST_PUSH: begin
                mem_wr    = 1'b1;
                mem_addr  = r_q.sp;
                mem_wdata = push_byte;
                r_d.sp    = r_q.sp - 1'b1;
                if (r_q.cnt == CW'(NB - 1)) begin
                    r_d.st = ST_SETI;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_SETI: begin
                mask_set = 1'b1;
                r_d.st   = ST_RDHI;
            end
            ST_RDHI: begin
                mem_rd   = 1'b1;
                mem_addr = vec_addr;
                r_d.st   = ST_RDLO;
            end
            ST_RDLO: begin
                mem_rd   = 1'b1;
                mem_addr = vec_addr + 1'b1;
                r_d.hi   = mem_rdata;
                r_d.st   = ST_GETLO;
            end
            ST_GETLO: begin
                r_d.lo = mem_rdata;
                r_d.st = ST_DONE;
            end
            ST_DONE: begin
                vec_done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign handler = {r_q.hi, r_q.lo};
    assign sp_o    = r_q.sp;

    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd)); // R4

    AST_PUSH_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == AW'($past(mem_addr) - 1'b1))); // R4

    AST_MASK_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set |=> (mem_rd && !mask_set)); // R5

    AST_MASK_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set |-> ($past(mem_wr) && !mem_wr)); // R5

    AST_VEC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == AW'($past(mem_addr) + 1'b1))); // R6

    AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(insn_done) && !$past(ccr_i[I_BIT]))); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_done |=> (!vec_done && !busy)); // R9

endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0;
    logic [N-1:0] src_flag = '0;
    logic [N-1:0] src_en = '0;
    logic [7:0]  ccr_i = 8'h00;
    logic [15:0] pc_i = '0;
    logic [7:0]  x_i = '0;
    logic [7:0]  a_i = '0;
    logic [15:0] sp_i = '0;
    logic [15:0] mem_addr;
    logic        mem_wr, mem_rd;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mask_set, busy, vec_done;
    logic [15:0] handler, sp_o;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done),
        .src_flag(src_flag), .src_en(src_en), .ccr_i(ccr_i),
        .pc_i(pc_i), .x_i(x_i), .a_i(a_i), .sp_i(sp_i),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mask_set(mask_set), .busy(busy), .vec_done(vec_done),
        .handler(handler), .sp_o(sp_o)
    );

    // vector memory model: data = low address byte XOR A5, one cycle latency
    always @(posedge clk) if (mem_rd) mem_rdata <= mem_addr[7:0] ^ 8'hA5;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_cycles(input string tag, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(tag, {busy, mem_wr, mem_rd}, 3'b000);
        end
    endtask

    // full entry: expects source idx to win; late >= 0 raises that source after first push
    task automatic run_entry(input int idx, input int late, input logic [15:0] pc,
                             input logic [7:0] x, input logic [7:0] a,
                             input logic [7:0] ccr, input logic [15:0] sp);
        logic [7:0]  exp_b [5];
        logic [15:0] base;
        exp_b[0] = pc[7:0]; exp_b[1] = pc[15:8]; exp_b[2] = x; exp_b[3] = a; exp_b[4] = ccr;
        base = 16'hFFC0 + 16'(2 * idx);
        pc_i = pc; x_i = x; a_i = a; ccr_i = ccr; sp_i = sp;
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        chk("R3 busy after boundary", busy, 1'b1);
        for (int k = 0; k < 5; k++) begin
            chk("R4 push strobe", {mem_wr, mem_rd}, 2'b10);
            chk("R4 push addr", mem_addr, sp - 16'(k));
            chk("R4 push data", mem_wdata, exp_b[k]);
            if (k == 0 && late >= 0) begin
                src_flag[late] = 1'b1;
                src_en[late]   = 1'b1;
                ccr_i = 8'h08;
            end
            @(negedge clk);
        end
        chk("R5 mask pulse, no access", {mask_set, mem_wr, mem_rd}, 3'b100);
        @(negedge clk);
        chk("R6 R7 R8 high read", {mem_rd, mem_addr}, {1'b1, base});
        chk("R5 mask one cycle", mask_set, 1'b0);
        @(negedge clk);
        chk("R6 low read", {mem_rd, mem_addr}, {1'b1, base + 16'd1});
        @(negedge clk);
        chk("R9 no early done", {vec_done, mem_rd}, 2'b00);
        @(negedge clk);
        chk("R9 done pulse", vec_done, 1'b1);
        chk("R6 handler", handler, {base[7:0] ^ 8'hA5, (base[7:0] + 8'd1) ^ 8'hA5});
        chk("R9 sp out", sp_o, sp - 16'd5);
        @(negedge clk);
        chk("R9 done one cycle", {vec_done, busy}, 2'b00);
        src_flag = '0; src_en = '0; ccr_i = 8'h00;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R10 reset idle", {busy, mem_wr, mem_rd, mask_set, vec_done}, 5'b0);
    endtask

    task automatic t_lowest;
        src_flag = 7'b0000001; src_en = 7'b0000001;
        run_entry(0, -1, 16'h1234, 8'h56, 8'h78, 8'h02, 16'h00FF);
    endtask

    task automatic t_highest;
        src_flag = 7'b1000000; src_en = 7'b1000000;
        run_entry(6, -1, 16'hBEEF, 8'hA1, 8'h3C, 8'hC1, 16'h0400);
    endtask

    task automatic t_priority;
        // R7: sources 1, 3, 4 pending; 5 flagged but disabled -> 4 wins
        src_flag = 7'b0111010; src_en = 7'b0011010;
        run_entry(4, -1, 16'h8001, 8'h11, 8'h22, 8'h00, 16'h0200);
    endtask

    task automatic t_disabled;
        // R1: flags without enables
        src_flag = 7'b1111111; src_en = 7'b0000000;
        insn_done = 1'b1;
        idle_cycles("R1 disabled flag ignored", 4);
        insn_done = 1'b0;
        src_flag = '0;
    endtask

    task automatic t_masked;
        // R2: mask bit set blocks entry, request stays pending
        src_flag = 7'b0000100; src_en = 7'b0000100;
        ccr_i = 8'h08;
        insn_done = 1'b1;
        idle_cycles("R2 masked no entry", 4);
        insn_done = 1'b0;
        run_entry(2, -1, 16'h4000, 8'h01, 8'h02, 8'h00, 16'h0100);
    endtask

    task automatic t_no_boundary;
        // R3: pending but no instruction boundary
        src_flag = 7'b0001000; src_en = 7'b0001000;
        insn_done = 1'b0;
        idle_cycles("R3 waits for boundary", 4);
        run_entry(3, -1, 16'h0ABC, 8'h44, 8'h55, 8'h20, 16'h0080);
    endtask

    task automatic t_latch;
        // R8: source 6 arrives during pushes, source 1 still fetched
        src_flag = 7'b0000010; src_en = 7'b0000010;
        run_entry(1, 6, 16'h7777, 8'h99, 8'h88, 8'h04, 16'h0300);
    endtask

    initial begin
        repeat (CLK_PERIOD * 1000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_lowest();
        t_highest();
        t_priority();
        t_disabled();
        t_masked();
        t_no_boundary();
        t_latch();
        idle_cycles("R10 quiet at end", 2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule